// File: doc/BRIEF.md
# Transmitter Output Power and Lock Sequencer

This block controls the line drivers of a parallel-to-serial transmitter while the chip enters and leaves power-down and while its clock multiplier acquires the reference clock. A single active-low power input (`pwr_on`) acts as an asynchronous force. When it is low, the block holds the multiplier disabled, disconnects the output termination and keeps the drivers in high impedance. When it goes high, the block enables the multiplier and connects the termination. It then waits a fixed number of reference clock periods, counted internally, before it lets the drivers transmit and raises a locked flag.

The controller has three states. In `SEQ_OFF` everything is disabled. In `SEQ_LOCKING` the multiplier and termination are on, the drivers are off, and the lock counter runs. In `SEQ_ACTIVE` everything is on. There are four transitions. Any state goes to `SEQ_OFF` asynchronously whenever `pwr_on` is low. `SEQ_OFF` goes to `SEQ_LOCKING` on the first clock edge with `pwr_on` high. `SEQ_LOCKING` goes to `SEQ_ACTIVE` on the edge where the counter is at its terminal count. `SEQ_ACTIVE` holds as long as `pwr_on` stays high.

Independently of the state, the block picks a termination strength from the coding mode. Uncoded (plain) traffic uses a high-resistance setting to save power. DC-balanced traffic uses the normal setting.

Top module: `tx_out_sequencer`

## Requirements
- R1: While `pwr_on` is 0, `mult_en`, `term_en`, `drv_en` and `locked` are all 0. They drop as soon as `pwr_on` falls, with no clock edge needed.
- R2: On the first rising `clk` edge with `pwr_on` at 1, the block enters `SEQ_LOCKING`. There `mult_en` = 1, `term_en` = 1, `drv_en` = 0 and `locked` = 0.
- R3: `drv_en` and `locked` rise on the edge that lies exactly `LOCK_CYCLES` edges after the edge that entered `SEQ_LOCKING` (default 32800). This is one cycle after the counter reaches `LOCK_CYCLES-1`. `drv_en` never rises unless `term_en` and `mult_en` were already 1.
- R4: The lock counter is `CNT_W` = 16 bits wide and never exceeds `LOCK_CYCLES-1`.
- R5: In `SEQ_ACTIVE`, `mult_en`, `term_en`, `drv_en` and `locked` are all 1, and they stay 1 while `pwr_on` remains 1.
- R6: Pulling `pwr_on` low from `SEQ_LOCKING` or `SEQ_ACTIVE` returns the block to `SEQ_OFF`. The next release waits the full `LOCK_CYCLES` again, with the counter restarting from zero.
- R7: `term_hi` is 1 (high-resistance termination) when `bal_mode` is 0 (plain), and 0 when `bal_mode` is 1 (DC-balanced). This holds in every state.
- R8: `bal_mode` has no effect on the state sequence or on its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| pwr_on | input | 1 | 0 forces power-down asynchronously; 1 runs the sequence |
| bal_mode | input | 1 | 1 = DC-balanced coding, 0 = plain coding |
| mult_en | output | 1 | Clock multiplier enable |
| term_en | output | 1 | Output termination connected |
| term_hi | output | 1 | 1 selects the high-resistance termination |
| drv_en | output | 1 | Line drivers enabled (0 = high impedance) |
| locked | output | 1 | Lock wait complete |

## Verification
The hardest case to create from the ports is a power-down that lands at a chosen point inside the lock wait, followed by a release that must start a fresh, full-length wait. With the default count, this point is tens of thousands of cycles deep. The bench therefore uses a second instance with a five-cycle wait. It sweeps the power-down point over every cycle of `SEQ_LOCKING` and into `SEQ_ACTIVE`, toggling `bal_mode` along the way. After each power-down it re-releases and checks the complete wait cycle by cycle. The default-count instance is run once to confirm the exact 32800-edge boundary.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF     = 2'b00,
        SEQ_LOCKING = 2'b01,
        SEQ_ACTIVE  = 2'b10
    } seq_state_t;
endpackage

// File: rtl/tx_lock_timer.sv
module tx_lock_timer #(
    parameter int LOCK_CYCLES = 32800,
    parameter int CNT_W       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] count;

    // Counter holds at zero outside the wait, so each new wait starts fresh.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (!run)
            count <= '0;
        else if (count != TERM)
            count <= count + 1'b1;
    end

    assign done = run && (count == TERM);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TERM);

    // R6: every entry into the wait begins at zero
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (count == '0));
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
    import tx_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_OFF:     nxt = SEQ_LOCKING;
            SEQ_LOCKING: if (done) nxt = SEQ_ACTIVE;
            SEQ_ACTIVE:  nxt = SEQ_ACTIVE;
            default:     nxt = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEQ_OFF;
        else
            state <= nxt;
    end

    assert_enter_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OFF) |=> (state == SEQ_LOCKING));

    assert_lock_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_LOCKING && done) |=> (state == SEQ_ACTIVE));

    assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ACTIVE) |=> (state == SEQ_ACTIVE));
endmodule

// File: rtl/tx_seq_outdec.sv
module tx_seq_outdec
    import tx_seq_pkg::*;
(
    input  seq_state_t state,
    input  logic       bal_mode,
    output logic       mult_en,
    output logic       term_en,
    output logic       term_hi,
    output logic       drv_en,
    output logic       locked
);
    always_comb begin
        mult_en = 1'b0;
        term_en = 1'b0;
        drv_en  = 1'b0;
        locked  = 1'b0;
        unique case (state)
            SEQ_OFF: ;
            SEQ_LOCKING: begin
                mult_en = 1'b1;
                term_en = 1'b1;
            end
            SEQ_ACTIVE: begin
                mult_en = 1'b1;
                term_en = 1'b1;
                drv_en  = 1'b1;
                locked  = 1'b1;
            end
            default: ;
        endcase
    end

    // Plain coding uses the low-power, high-resistance termination.
    assign term_hi = ~bal_mode;
endmodule

// File: rtl/tx_out_sequencer.sv
module tx_out_sequencer
    import tx_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 32800,
    parameter int CNT_W       = 16
) (
    input  logic clk,
    input  logic pwr_on,
    input  logic bal_mode,
    output logic mult_en,
    output logic term_en,
    output logic term_hi,
    output logic drv_en,
    output logic locked
);
    seq_state_t state;
    logic       done;

    tx_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(pwr_on),
        .run  (state == SEQ_LOCKING),
        .done (done)
    );

    tx_seq_fsm u_fsm (
        .clk  (clk),
        .rst_n(pwr_on),
        .done (done),
        .state(state)
    );

    tx_seq_outdec u_dec (
        .state   (state),
        .bal_mode(bal_mode),
        .mult_en (mult_en),
        .term_en (term_en),
        .term_hi (term_hi),
        .drv_en  (drv_en),
        .locked  (locked)
    );

    assert_off_quiet_R1: assert property (@(posedge clk)
        !pwr_on |-> (!mult_en && !term_en && !drv_en && !locked));

    assert_drv_after_wait_R3: assert property (@(posedge clk) disable iff (!pwr_on)
        $rose(drv_en) |-> ($past(term_en) && $past(mult_en) && !$past(drv_en)));
endmodule

// File: tb/tx_out_sequencer_bench.sv
module tx_out_sequencer_bench;
    localparam int SMALL = 5;
    localparam int BIG   = 32800;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic s_pwr = 1'b0, s_bal = 1'b0;
    logic s_mult, s_term, s_hi, s_drv, s_lock;
    logic b_pwr = 1'b0, b_bal = 1'b1;
    logic b_mult, b_term, b_hi, b_drv, b_lock;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    tx_out_sequencer #(.LOCK_CYCLES(SMALL)) u_tx_out_sequencer (
        .clk(clk), .pwr_on(s_pwr), .bal_mode(s_bal),
        .mult_en(s_mult), .term_en(s_term), .term_hi(s_hi),
        .drv_en(s_drv), .locked(s_lock)
    );

    tx_out_sequencer #(.LOCK_CYCLES(BIG)) u_big (
        .clk(clk), .pwr_on(b_pwr), .bal_mode(b_bal),
        .mult_en(b_mult), .term_en(b_term), .term_hi(b_hi),
        .drv_en(b_drv), .locked(b_lock)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Packed output vector {mult,term,drv,locked}
    function automatic int s_vec();
        return {28'd0, s_mult, s_term, s_drv, s_lock};
    endfunction

    // Expected after n edges since release: entry at n=1, active from n=SMALL+1
    function automatic int exp_vec(input int n);
        if (n < 1)         return 0;
        if (n <= SMALL)    return 4'b1100;
        return 4'b1111;
    endfunction

    // Release, track every cycle, power down after abort_at edges
    task automatic run_small(input int abort_at);
        @(negedge clk);
        s_pwr = 1'b1;
        #1 chk(s_vec() == 0, "R2 no change before edge", s_vec(), 0);
        for (int n = 1; n <= abort_at; n++) begin
            @(negedge clk);
            chk(s_vec() == exp_vec(n), (n <= SMALL) ? "R2/R3 wait" : "R3/R5 active",
                s_vec(), exp_vec(n));
            s_bal = ~s_bal;  // R8: mode toggling must not move the timing
            #1 chk(s_hi == ~s_bal, "R7 term select", s_hi, ~s_bal);
        end
        s_pwr = 1'b0;
        #1 chk(s_vec() == 0, "R1 async off", s_vec(), 0);
        chk(s_hi == ~s_bal, "R7 term select in off", s_hi, ~s_bal);
    endtask

    initial begin
        #2;
        chk(s_vec() == 0, "R1 reset state", s_vec(), 0);
        chk(s_hi == 1'b1, "R7 plain selects high", s_hi, 1);
        chk(b_hi == 1'b0, "R7 balanced selects normal", b_hi, 0);
        repeat (3) @(negedge clk);
        chk(s_vec() == 0, "R1 held off with clock", s_vec(), 0);
        // R6 sweep: power-down at each point of the wait and into active
        for (int a = 1; a <= SMALL + 3; a++) begin
            run_small(a);
            repeat (2) @(negedge clk);
            chk(s_vec() == 0, "R6 off after power-down", s_vec(), 0);
        end
        // Long active hold (R5)
        run_small(SMALL + 40);

        // Full-length count on the default instance
        @(negedge clk);
        b_pwr = 1'b1;
        for (int n = 1; n <= BIG + 1; n++) begin
            @(negedge clk);
            if (n == 1)
                chk({b_mult, b_term, b_drv, b_lock} == 4'b1100, "R2 big entry",
                    {b_mult, b_term, b_drv, b_lock}, 4'b1100);
            if (n == BIG)
                chk(!b_drv && !b_lock, "R3 big not yet driving", {b_drv, b_lock}, 0);
            if (n == BIG + 1)
                chk(b_drv && b_lock, "R3 big drives at 32800", {b_drv, b_lock}, 3);
        end
        b_pwr = 1'b0;
        #1 chk({b_mult, b_term, b_drv, b_lock} == 0, "R1 big async off",
               {b_mult, b_term, b_drv, b_lock}, 0);
        // R6 on the full count: restart from zero after a mid-wait power-down
        @(negedge clk);
        b_pwr = 1'b1;
        repeat (100) @(negedge clk);
        b_pwr = 1'b0;
        @(negedge clk);
        b_pwr = 1'b1;
        for (int n = 1; n <= BIG + 1; n++) begin
            @(negedge clk);
            if (n == BIG)
                chk(!b_drv, "R6 big restart full wait", b_drv, 0);
            if (n == BIG + 1)
                chk(b_drv, "R6 big restart drives", b_drv, 1);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule